// File: doc/BRIEF.md
# Shared State-Register Task Sequencer

This block sequences the task modules that bring up and service an external network controller chip. A single 3-bit state register holds the code of the task that currently owns control. Each task compares that register with its own code and is active only while they match. When an active task finishes its work, it writes the code of its successor back into the register, and that hands control on. There is no central next-state function: the successor is chosen by whichever task is active.

Five tasks are provided as stubs:
- the hard-reset task (code 000);
- the soft-reset task (001);
- the idle task (010), which waits for a receive-queue-not-empty interrupt or a soft-reset request;
- the reader task (011);
- a follow-up task (100), which both reset tasks hand over to.

Each stub finishes when its own completion input is high. The register updates only on a clock-enable pulse, which the block generates itself once every `DIV` clock cycles. With the default `DIV` of 4 and a 20 MHz clock, the sequencer advances at an effective 5 MHz.

Top module: `task_seq_top`

## Requirements
- R1: A synchronous active-high `rst` loads code 000 into `state`. While `state` is 000, `taskActive` equals 5'b00001 (bit i of `taskActive` is high exactly when `state` equals i).
- R2: `tick` is high for one cycle in every `DIV` cycles (4 by default). `state` changes only on a clock edge at which `tick` was high.
- R3: While `state` is 000, `hardDone` high at a tick loads 100.
- R4: While `state` is 001, `softDone` high at a tick loads 100.
- R5: While `state` is 010, with `softReq` low, `rxNotEmpty` high at a tick loads 011.
- R6: While `state` is 010, `softReq` high at a tick loads 001, and it takes priority over `rxNotEmpty`. In any other state, `softReq` has no effect on `state`.
- R7: While `state` is 011, `readDone` high at a tick loads 010. While `state` is 100, `tailDone` high at a tick loads 010.
- R8: `state` holds its value while the active task's completion input is low. Completion inputs that belong to inactive tasks have no effect.
- R9: At most one task drives the register write port in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hardDone | input | 1 | Completion of the hard-reset task |
| softDone | input | 1 | Completion of the soft-reset task |
| rxNotEmpty | input | 1 | Receive-queue-not-empty interrupt, seen by the idle task |
| softReq | input | 1 | Soft-reset request, seen by the idle task only |
| readDone | input | 1 | Completion of the reader task |
| tailDone | input | 1 | Completion of the code-100 task |
| tick | output | 1 | Clock-enable pulse, one cycle in DIV |
| state | output | 3 | Shared state register |
| taskActive | output | 5 | One bit per task, high when `state` holds that task's code |

## Verification
The assertions check four things on every cycle:
- that no two tasks assert write-enable together;
- that `state` never moves except after a tick;
- that reset leaves code 000;
- that each active task's completion at a tick leads to its successor's code on the next edge.

Only the bench's scenarios can show the behaviours that depend on inputs reaching a task that is not active. These are the full hand-off chains, the hold over long waits, `softReq` being ignored outside the idle state, and stray completion pulses being ignored.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int STATE_W   = 3;
  localparam int NUM_TASKS = 5;

  localparam logic [STATE_W-1:0] ST_HARD = 3'd0;
  localparam logic [STATE_W-1:0] ST_SOFT = 3'd1;
  localparam logic [STATE_W-1:0] ST_IDLE = 3'd2;
  localparam logic [STATE_W-1:0] ST_READ = 3'd3;
  localparam logic [STATE_W-1:0] ST_TAIL = 3'd4;

  // Strobes from the task logic to the register datapath
  typedef struct packed {
    logic [NUM_TASKS-1:0]              wrEn;
    logic [NUM_TASKS-1:0][STATE_W-1:0] nextVal;
  } seq_ctrl_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  seq_ctrl_t          ctrl,
  output logic               tick,
  output logic [STATE_W-1:0] state
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0]   divCnt;
  logic [STATE_W-1:0] muxVal;
  logic               anyWr;

  always_ff @(posedge clk) begin
    if (rst || divCnt == CNT_LAST) divCnt <= '0;
    else                           divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == CNT_LAST);

  // Released write port: only enabled writers contribute to the OR
  always_comb begin
    muxVal = '0;
    for (int i = 0; i < NUM_TASKS; i++) begin
      if (ctrl.wrEn[i]) muxVal = muxVal | ctrl.nextVal[i];
    end
  end

  assign anyWr = |ctrl.wrEn;

  always_ff @(posedge clk) begin
    if (rst)                state <= ST_HARD;
    else if (tick && anyWr) state <= muxVal;
  end

  // R9: single writer on the port
  a_r9_one_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl.wrEn));

  // R2: state moves only after an enabled cycle
  a_r2_tick_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(rst)) |-> $stable(state));

  // R1: reset leaves the hard-reset code
  a_r1_reset_code: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == ST_HARD));
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [STATE_W-1:0]   state,
  input  logic                 tick,
  input  logic                 hardDone,
  input  logic                 softDone,
  input  logic                 rxNotEmpty,
  input  logic                 softReq,
  input  logic                 readDone,
  input  logic                 tailDone,
  output seq_ctrl_t            ctrl,
  output logic [NUM_TASKS-1:0] taskActive
);
  logic [NUM_TASKS-1:0]              finish;
  logic [NUM_TASKS-1:0][STATE_W-1:0] succ;

  // Per-task completion condition and successor code
  always_comb begin
    finish          = '0;
    succ            = '0;
    finish[ST_HARD] = hardDone;
    succ[ST_HARD]   = ST_TAIL;
    finish[ST_SOFT] = softDone;
    succ[ST_SOFT]   = ST_TAIL;
    finish[ST_IDLE] = rxNotEmpty | softReq;
    succ[ST_IDLE]   = softReq ? ST_SOFT : ST_READ;
    finish[ST_READ] = readDone;
    succ[ST_READ]   = ST_IDLE;
    finish[ST_TAIL] = tailDone;
    succ[ST_TAIL]   = ST_IDLE;
  end

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_task
    assign taskActive[i]   = (state == STATE_W'(i));
    assign ctrl.wrEn[i]    = taskActive[i] & tick & finish[i];
    assign ctrl.nextVal[i] = succ[i];
  end

  // R3
  a_r3_hard_next: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HARD && tick && hardDone) |=> (state == ST_TAIL));
  // R4
  a_r4_soft_next: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SOFT && tick && softDone) |=> (state == ST_TAIL));
  // R5
  a_r5_idle_read: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && tick && rxNotEmpty && !softReq) |=> (state == ST_READ));
  // R6
  a_r6_idle_soft: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && tick && softReq) |=> (state == ST_SOFT));
  // R7
  a_r7_back_idle: assert property (@(posedge clk) disable iff (rst)
    (tick && ((state == ST_READ && readDone) || (state == ST_TAIL && tailDone)))
      |=> (state == ST_IDLE));
endmodule

// File: rtl/task_seq_top.sv
module task_seq_top
  import seq_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hardDone,
  input  logic                 softDone,
  input  logic                 rxNotEmpty,
  input  logic                 softReq,
  input  logic                 readDone,
  input  logic                 tailDone,
  output logic                 tick,
  output logic [STATE_W-1:0]   state,
  output logic [NUM_TASKS-1:0] taskActive
);
  seq_ctrl_t ctrlBus;

  seq_control u_ctrl (
    .clk(clk), .rst(rst), .state(state), .tick(tick),
    .hardDone(hardDone), .softDone(softDone), .rxNotEmpty(rxNotEmpty),
    .softReq(softReq), .readDone(readDone), .tailDone(tailDone),
    .ctrl(ctrlBus), .taskActive(taskActive)
  );

  seq_datapath #(.DIV(DIV)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrlBus), .tick(tick), .state(state)
  );
endmodule

// File: tb/tb_task_seq_top.sv
module tb_task_seq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hardDone = 0, softDone = 0, rxNotEmpty = 0, softReq = 0, readDone = 0, tailDone = 0;
  logic tick;
  logic [2:0] state;
  logic [4:0] taskActive;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task_seq_top #(.DIV(4)) dut (
    .clk(clk), .rst(rst), .hardDone(hardDone), .softDone(softDone),
    .rxNotEmpty(rxNotEmpty), .softReq(softReq), .readDone(readDone),
    .tailDone(tailDone), .tick(tick), .state(state), .taskActive(taskActive)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Wait at negedges for state to reach want; record whether the edge followed a tick
  task automatic waitFor(input string req, input logic [2:0] want, input int limit);
    logic prevTick = 1'b0;
    bit hit = 0;
    bit viaTick = 0;
    for (int i = 0; i < limit && !hit; i++) begin
      prevTick = tick;
      @(negedge clk);
      if (state == want) begin
        hit = 1;
        viaTick = prevTick;
      end
    end
    check(req, {29'd0, state}, {29'd0, want});
    check("R2 change after tick", {31'd0, viaTick}, 32'd1);
    check("R1 active decode", {27'd0, taskActive}, 32'd1 << want);
  endtask

  task automatic holdFor(input string req, input logic [2:0] want, input int n);
    bit moved = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (state != want) moved = 1;
    end
    check(req, {31'd0, moved}, 32'd0);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    check("R1 reset code", {29'd0, state}, 32'd0);
    check("R1 reset active", {27'd0, taskActive}, 32'h1);
    rst = 0;
  endtask

  task automatic testTickPeriod();
    int gap = 0;
    int seen = 0;
    int lastAt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick) begin
        if (seen > 0) gap = i - lastAt;
        lastAt = i;
        seen++;
      end
    end
    check("R2 tick period", gap, 4);
  endtask

  task automatic testHardChain();
    holdFor("R8 hold in 000", 3'd0, 40);
    readDone = 1; tailDone = 1; softDone = 1;
    holdFor("R8 inactive done ignored", 3'd0, 12);
    readDone = 0; tailDone = 0; softDone = 0;
    hardDone = 1;
    waitFor("R3 hard to 100", 3'd4, 12);
    hardDone = 0;
    softReq = 1;
    holdFor("R6 softReq ignored in 100", 3'd4, 12);
    softReq = 0;
    tailDone = 1;
    waitFor("R7 tail to 010", 3'd2, 12);
    tailDone = 0;
    holdFor("R8 hold in 010", 3'd2, 16);
    rxNotEmpty = 1;
    waitFor("R5 idle to 011", 3'd3, 12);
    rxNotEmpty = 0;
    softReq = 1;
    holdFor("R6 softReq ignored in 011", 3'd3, 12);
    softReq = 0;
    readDone = 1;
    waitFor("R7 read to 010", 3'd2, 12);
    readDone = 0;
  endtask

  task automatic testSoftChain();
    softReq = 1;
    waitFor("R6 idle to 001", 3'd1, 12);
    softReq = 0;
    holdFor("R8 hold in 001", 3'd1, 12);
    softDone = 1;
    waitFor("R4 soft to 100", 3'd4, 12);
    softDone = 0;
    tailDone = 1;
    waitFor("R7 tail to 010 again", 3'd2, 12);
    tailDone = 0;
  endtask

  task automatic testPriority();
    softReq = 1; rxNotEmpty = 1;
    waitFor("R6 softReq over rx", 3'd1, 12);
    softReq = 0; rxNotEmpty = 0;
  endtask

  initial begin
    doReset();
    testTickPeriod();
    testHardChain();
    testSoftChain();
    testPriority();
    doReset();
    holdFor("R8 hold after mid-run reset", 3'd0, 12);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule